// File: doc/BRIEF.md
# Latched-address 3-to-8 decoder

This block turns a 3-bit address into eight active-low select lines, of which at most one is low at any time. An address-holding stage sits in front of the decoder. While the hold control is low, the stage is transparent and the selects follow the live address with no added cycle. Once the hold control is high, the address registered at the last clock edge where hold was low stays in force. Further changes on the address pins then have no effect.

Two gate inputs of opposite polarity control whether any select can go low. The gate is open only when the active-low gate is low and the active-high gate is high. Gating acts on the outputs only and leaves the stored address alone. Because the two gates have opposite polarity, higher address bits can drive them directly. Several instances that share one hold line therefore form a wider decoder with a stored address and no extra logic.

The whole block runs on one clock. A synchronous reset clears the stored address to zero.

Top module: `addr_latch_decoder`

## Requirements
- R1: While `hold` is low, the selects decode the live `addr_in` combinationally, within the same cycle.
- R2: The stored address is the `addr_in` value sampled at the last rising clock edge at which `hold` was low; while `hold` is high, that value drives the decoder.
- R3: While `hold` stays high, changes on `addr_in` leave `sel_n` unchanged.
- R4: All `sel_n` bits are 1 unless `gate_n` is 0 and `gate` is 1.
- R5: Closing and reopening the gate while `hold` is high does not alter the stored address. After reopening, the same select goes low again.
- R6: When the gate is open, exactly one bit of `sel_n` is 0. Its index equals the effective address, with `addr_in[0]` as the least significant bit. When the gate is closed, no bit is 0.
- R7: A rising clock edge with `rst` high clears the stored address to 0.
- R8: Two instances that share `hold` form a 4-to-16 decoder with a stored address. The low instance has `gate_n` = address bit 3 and `gate` tied to 1. The high instance has `gate_n` tied to 0 and `gate` = address bit 3. Exactly one of the 16 selects is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high; clears the stored address |
| addr_in | input | ADDR_W | Address to decode |
| hold | input | 1 | Low: transparent; high: keep the stored address |
| gate_n | input | 1 | Active-low output gate |
| gate | input | 1 | Active-high output gate |
| sel_n | output | 2**ADDR_W | Active-low one-hot selects |

## Verification
The table first walks all eight addresses with the gate open and `hold` low. This shows whether each index maps to its own select line and whether bit 0 is the least significant bit. It then tries all four gate combinations on a fixed address, which separates the one open combination from the three closed ones.

Directed sequences capture an address, then toggle `addr_in` and close and reopen the gate while `hold` is high. These steps distinguish a true capture from a transparent path and from gating that corrupts the stored value. A reset taken while `hold` is high shows that the stored value returns to zero.

A cascaded pair walks all 16 addresses and then holds one of them. This checks that the opposite-polarity gates split the range with exactly one low select.

// File: rtl/alat_pkg.sv
package alat_pkg;

    // The output gate is open only for the one combination of the two polarities.
    function automatic logic gate_open(input logic g_n, input logic g);
        return (~g_n) & g;
    endfunction

endpackage

// File: rtl/alat_hold.sv
module alat_hold #(
    parameter int ADDR_W = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              hold,
    input  logic [ADDR_W-1:0] addr_in,
    output logic [ADDR_W-1:0] addr_eff
);
    typedef struct packed {
        logic [ADDR_W-1:0] addr;
    } hold_state_t;

    hold_state_t st_d, st_q;

    // Next state: follow the input while transparent, else keep.
    always_comb begin
        st_d = st_q;
        if (rst) begin
            st_d.addr = '0;
        end else if (!hold) begin
            st_d.addr = addr_in;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    // Transparent path bypasses the register so decoding needs no extra cycle.
    assign addr_eff = hold ? st_q.addr : addr_in;

endmodule

// File: rtl/alat_onehot.sv
module alat_onehot #(
    parameter int ADDR_W = 3,
    localparam int OUT_N = 1 << ADDR_W
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [OUT_N-1:0]  hot
);
    for (genvar i = 0; i < OUT_N; i++) begin : g_line
        assign hot[i] = (addr == ADDR_W'(i));
    end
endmodule

// File: rtl/alat_gate.sv
module alat_gate #(
    parameter int OUT_N = 8
) (
    input  logic             gate_n,
    input  logic             gate,
    input  logic [OUT_N-1:0] hot,
    output logic [OUT_N-1:0] sel_n
);
    import alat_pkg::*;

    always_comb begin
        if (gate_open(gate_n, gate)) begin
            sel_n = ~hot;
        end else begin
            sel_n = '1;
        end
    end
endmodule

// File: rtl/addr_latch_decoder.sv
module addr_latch_decoder #(
    parameter int ADDR_W = 3,
    localparam int OUT_N = 1 << ADDR_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic              hold,
    input  logic              gate_n,
    input  logic              gate,
    output logic [OUT_N-1:0]  sel_n
);
    logic [ADDR_W-1:0] addr_eff;
    logic [OUT_N-1:0]  hot;

    alat_hold #(.ADDR_W(ADDR_W)) u_hold (
        .clk      (clk),
        .rst      (rst),
        .hold     (hold),
        .addr_in  (addr_in),
        .addr_eff (addr_eff)
    );

    alat_onehot #(.ADDR_W(ADDR_W)) u_dec (
        .addr (addr_eff),
        .hot  (hot)
    );

    alat_gate #(.OUT_N(OUT_N)) u_gate (
        .gate_n (gate_n),
        .gate   (gate),
        .hot    (hot),
        .sel_n  (sel_n)
    );
endmodule

// File: rtl/alat_checker.sv
module alat_checker #(
    parameter int ADDR_W = 3,
    localparam int OUT_N = 1 << ADDR_W
) (
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] addr_in,
    input logic              hold,
    input logic              gate_n,
    input logic              gate,
    input logic [OUT_N-1:0]  sel_n
);
    // R1
    transparent_decode_chk: assert property (@(posedge clk) disable iff (rst)
        (!hold && !gate_n && gate) |-> (sel_n[addr_in] == 1'b0));

    // R3
    held_addr_ignored_chk: assert property (@(posedge clk) disable iff (rst)
        (hold && $past(hold) && $past(!rst) && !gate_n && gate && $stable(gate_n) && $stable(gate))
        |-> $stable(sel_n));

    // R4
    gate_closed_chk: assert property (@(posedge clk) disable iff (rst)
        !(!gate_n && gate) |-> (sel_n == '1));

    // R6
    one_low_chk: assert property (@(posedge clk) disable iff (rst)
        (!gate_n && gate) |-> ($countones(~sel_n) == 1));

    // R6
    never_two_low_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(~sel_n));
endmodule

bind addr_latch_decoder alat_checker #(.ADDR_W(ADDR_W)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .addr_in (addr_in),
    .hold    (hold),
    .gate_n  (gate_n),
    .gate    (gate),
    .sel_n   (sel_n)
);

// File: tb/tb_addr_latch_decoder.sv
module tb_addr_latch_decoder;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [2:0] addr_in = '0;
    logic       hold = 1'b0;
    logic       gate_n = 1'b1;
    logic       gate = 1'b0;
    logic [7:0] sel_n;

    logic [3:0]  wide_addr = '0;
    logic [7:0]  lo_sel_n, hi_sel_n;
    logic [15:0] wide_sel_n;

    int n_run = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    addr_latch_decoder dut (
        .clk(clk), .rst(rst), .addr_in(addr_in), .hold(hold),
        .gate_n(gate_n), .gate(gate), .sel_n(sel_n)
    );

    // R8 cascade: bit 3 steers the two opposite-polarity gates
    addr_latch_decoder u_lo (
        .clk(clk), .rst(rst), .addr_in(wide_addr[2:0]), .hold(hold),
        .gate_n(wide_addr[3]), .gate(1'b1), .sel_n(lo_sel_n)
    );
    addr_latch_decoder u_hi (
        .clk(clk), .rst(rst), .addr_in(wide_addr[2:0]), .hold(hold),
        .gate_n(1'b0), .gate(wide_addr[3]), .sel_n(hi_sel_n)
    );
    assign wide_sel_n = {hi_sel_n, lo_sel_n};

    // Vector: {hold, gate_n, gate, addr[2:0], expected sel_n[7:0]}
    localparam int NVEC = 12;
    localparam logic [13:0] VEC [NVEC] = '{
        {1'b0, 1'b0, 1'b1, 3'd0, 8'b1111_1110},
        {1'b0, 1'b0, 1'b1, 3'd1, 8'b1111_1101},
        {1'b0, 1'b0, 1'b1, 3'd2, 8'b1111_1011},
        {1'b0, 1'b0, 1'b1, 3'd3, 8'b1111_0111},
        {1'b0, 1'b0, 1'b1, 3'd4, 8'b1110_1111},
        {1'b0, 1'b0, 1'b1, 3'd5, 8'b1101_1111},
        {1'b0, 1'b0, 1'b1, 3'd6, 8'b1011_1111},
        {1'b0, 1'b0, 1'b1, 3'd7, 8'b0111_1111},
        {1'b0, 1'b1, 1'b1, 3'd5, 8'b1111_1111},
        {1'b0, 1'b0, 1'b0, 3'd5, 8'b1111_1111},
        {1'b0, 1'b1, 1'b0, 3'd5, 8'b1111_1111},
        {1'b0, 1'b0, 1'b1, 3'd5, 8'b1101_1111}
    };

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %b expected %b", req, act, exp);
        end
    endtask

    function automatic logic [7:0] model(input logic [2:0] a, input logic gn, input logic g);
        return (!gn && g) ? ~(8'd1 << a) : 8'hFF;
    endfunction

    // Drive just after a falling edge, then sample mid-phase.
    task automatic step;
        @(negedge clk);
    endtask

    initial begin
        #2_000_000;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        // Reset state: stored address cleared, gate closed
        step(); step();
        check("R7 reset gate closed", {8'h00, sel_n}, {8'h00, 8'hFF});
        rst = 1'b0;

        // R1 / R4 / R6 table walk
        for (int i = 0; i < NVEC; i++) begin
            step();
            hold    = VEC[i][13];
            gate_n  = VEC[i][12];
            gate    = VEC[i][11];
            addr_in = VEC[i][10:8];
            #2;
            check("R1/R4/R6 table", {8'h00, sel_n}, {8'h00, VEC[i][7:0]});
            check("R6 model", {8'h00, sel_n}, {8'h00, model(addr_in, gate_n, gate)});
        end

        // R2: capture 3, then raise hold and move the address
        step(); hold = 1'b0; addr_in = 3'd3; gate_n = 1'b0; gate = 1'b1;
        step(); hold = 1'b1; addr_in = 3'd7;
        #2;
        check("R2 captured address", {8'h00, sel_n}, {8'h00, model(3'd3, 1'b0, 1'b1)});

        // R3: address changes while held have no effect
        for (int a = 0; a < 8; a++) begin
            step(); addr_in = 3'(a);
            #2;
            check("R3 held address", {8'h00, sel_n}, {8'h00, model(3'd3, 1'b0, 1'b1)});
        end

        // R4 / R5: close the gate, then reopen it
        step(); gate = 1'b0; addr_in = 3'd6;
        #2;
        check("R4 gate closed while held", {8'h00, sel_n}, {8'h00, 8'hFF});
        step(); gate_n = 1'b1; gate = 1'b1;
        #2;
        check("R4 gate_n high while held", {8'h00, sel_n}, {8'h00, 8'hFF});
        step(); gate_n = 1'b0;
        #2;
        check("R5 stored address after reopen", {8'h00, sel_n}, {8'h00, model(3'd3, 1'b0, 1'b1)});

        // R1: dropping hold returns to the live address at once
        step(); hold = 1'b0;
        #2;
        check("R1 transparent again", {8'h00, sel_n}, {8'h00, model(3'd6, 1'b0, 1'b1)});

        // R7: reset while held clears the stored address to 0
        step(); hold = 1'b1; rst = 1'b1;
        step(); rst = 1'b0; addr_in = 3'd5;
        #2;
        check("R7 reset clears stored address", {8'h00, sel_n}, {8'h00, model(3'd0, 1'b0, 1'b1)});

        // R8: cascade across all 16 addresses, transparent
        step(); hold = 1'b0;
        for (int w = 0; w < 16; w++) begin
            step(); wide_addr = 4'(w);
            #2;
            check("R8 cascade decode", wide_sel_n, ~(16'd1 << w));
        end
        // R8: hold address 11, then sweep the inputs
        step(); wide_addr = 4'd11;
        step(); hold = 1'b1;
        for (int w = 0; w < 16; w++) begin
            step(); wide_addr = {wide_addr[3], 3'(w)};
            #2;
            check("R8 cascade held", wide_sel_n, (wide_addr[3] ? ~(16'd1 << 11) : ~(16'd1 << 3)));
        end

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule